// File: doc/BRIEF.md
# Run-Time Lane-Width SIMD Absolute-Value and Negate Unit

This block takes one 32-bit instruction word and a 128-bit source vector in the same cycle. It recognises two forms. The first is a packed-vector absolute-value or negate operation. The second is a scalar 64-bit variant of the same operation. It then processes every signed lane of the source at once.

The size field of the instruction picks the lane width: 8, 16, 32 or 64 bits. A length bit picks whether the lower 64 bits or all 128 bits take part. One more bit chooses negation instead of the absolute value.

The result, the destination register index and two status flags come out of a single register stage. One flag says that the result is valid. The other says that the word was not an accepted encoding. The unit holds no register file, so the source operand arrives on a port and the source-register field of the word is ignored.

Top module: `simd_absneg_unit`

## Requirements
- R1: A word with bit 31 = 0, bits 28:24 = 01110 and bits 21:10 = 100000101110 is a vector operation. The plain form of it is 0x0E20B800. When `op_valid_i` is high, such a word gives `valid_o` = 1 and `undef_o` = 0 in the following cycle, unless R8 applies.
- R2: In the vector form, bits 23:22 (value s) set the lane width to 8 << s bits. The lanes are packed from bit 0 upward.
- R3: In the vector form, bit 30 = 0 processes only bits 63:0 and drives result bits 127:64 to zero. Bit 30 = 1 processes all 128 bits.
- R4: With bit 29 = 0, each lane of the result holds the absolute value of the matching signed source lane. No carry or borrow crosses a lane boundary.
- R5: A lane holding the most negative value for its width comes out unchanged, in both absolute and negate mode. The value wraps and does not saturate.
- R6: With bit 29 = 1, each lane of the result holds the two's-complement negation of its source lane.
- R7: A word with bits 31:30 = 01, bits 28:24 = 11110, bits 23:22 = 11 and bits 21:10 = 100000101110 is the scalar form (0x5EE0B800 for absolute value, 0x7EE0B800 with bit 29 set for negate). It treats bits 63:0 as one 64-bit lane and zeroes bits 127:64.
- R8: A vector-form word with bits 23:22 = 11 and bit 30 = 0 raises `undef_o` in the next cycle. `valid_o` stays low and the result is zero.
- R9: A word with `op_valid_i` high that matches neither form raises `undef_o` in the next cycle. `valid_o` stays low and the result is all zeros.
- R10: With `op_valid_i` low, both `valid_o` and `undef_o` are low in the next cycle and the result is zero.
- R11: A synchronous active-high `rst` clears `valid_o`, `undef_o`, `res_o` and `rd_o` at the next clock edge.
- R12: `rd_o` shows bits 4:0 of the last word presented with `op_valid_i` high, one cycle after that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Instruction word and source are presented this cycle |
| instr_i | input | 32 | Instruction word |
| src_i | input | VEC_W (128) | Source vector |
| res_o | output | VEC_W (128) | Registered result vector |
| rd_o | output | 5 | Registered destination register index |
| valid_o | output | 1 | Result holds a recognised operation |
| undef_o | output | 1 | Presented word was not an accepted encoding |

## Verification
On every cycle, the assertions check the following. The two flags never rise together. An idle cycle leaves both flags low. Words outside either major opcode are rejected, and so is the short-vector 64-bit-lane combination. A short-vector request always gives a zero upper half. The destination index follows the word. The byte-lane wrap of 0x80 holds.

Only the bench's scenarios can show the lane arithmetic itself. That covers the correct width chosen per size value, lane independence, negation, the scalar form's single wide lane, and reset in the middle of traffic. The bench compares every result against a lane-by-lane model, using random words and vectors seeded with extreme values.

// File: rtl/sabs_pkg.sv
package sabs_pkg;

  localparam int INSTR_W   = 32;
  localparam int VEC_W     = 128;
  localparam int REG_IDX_W = 5;
  localparam int N_SIZES   = 4;

  localparam logic [4:0]  VEC_MAJOR = 5'b01110;
  localparam logic [4:0]  SCA_MAJOR = 5'b11110;
  localparam logic [11:0] TAIL_CODE = 12'b1000_0010_1110;

  typedef enum logic [1:0] {
    LANE_B = 2'd0,
    LANE_H = 2'd1,
    LANE_S = 2'd2,
    LANE_D = 2'd3
  } lane_sz_e;

  typedef struct packed {
    logic                 match;
    logic                 negate;
    logic                 full;
    lane_sz_e             lsz;
    logic [REG_IDX_W-1:0] rd;
  } dec_t;

endpackage

// File: rtl/sabs_decode.sv
module sabs_decode
  import sabs_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);

  logic tail_ok;
  logic is_vec;
  logic is_sca;
  logic rn_unused;

  // Source-register field is not needed: the operand arrives on a port.
  assign rn_unused = ^instr_i[9:5];

  always_comb begin
    tail_ok = (instr_i[21:10] == TAIL_CODE);
    is_vec  = !instr_i[31] && (instr_i[28:24] == VEC_MAJOR) && tail_ok;
    is_sca  = (instr_i[31:30] == 2'b01) && (instr_i[28:24] == SCA_MAJOR) &&
              (instr_i[23:22] == 2'b11) && tail_ok;

    dec_o        = '0;
    dec_o.negate = instr_i[29];
    dec_o.rd     = instr_i[REG_IDX_W-1:0];

    if (is_sca) begin
      dec_o.match = 1'b1;
      dec_o.full  = 1'b0;
      dec_o.lsz   = LANE_D;
    end else if (is_vec) begin
      // 64-bit lanes in a 64-bit vector are rejected.
      dec_o.match = !((instr_i[23:22] == 2'b11) && !instr_i[30]);
      dec_o.full  = instr_i[30];
      dec_o.lsz   = lane_sz_e'(instr_i[23:22]);
    end
  end

endmodule

// File: rtl/sabs_lane_bank.sv
module sabs_lane_bank #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 8
) (
  input  logic [VEC_W-1:0] src_i,
  input  logic             neg_i,
  output logic [VEC_W-1:0] res_o
);

  localparam int N_LANES = VEC_W / LANE_W;

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] a;
    logic              flip;

    assign a    = src_i[l*LANE_W +: LANE_W];
    assign flip = neg_i | a[LANE_W-1];
    // Subtraction is confined to LANE_W bits, so the most negative value wraps.
    assign res_o[l*LANE_W +: LANE_W] = flip ? (LANE_W'(0) - a) : a;
  end

endmodule

// File: rtl/simd_absneg_unit.sv
module simd_absneg_unit
  import sabs_pkg::*;
#(
  parameter int VEC_W = sabs_pkg::VEC_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 op_valid_i,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic [VEC_W-1:0]     src_i,
  output logic [VEC_W-1:0]     res_o,
  output logic [REG_IDX_W-1:0] rd_o,
  output logic                 valid_o,
  output logic                 undef_o
);

  localparam int HALF_W = VEC_W / 2;
  localparam logic [VEC_W-1:0] LOW_MASK = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

  dec_t             dec;
  logic [VEC_W-1:0] bank_res [N_SIZES];
  logic [VEC_W-1:0] lane_sel;
  logic [VEC_W-1:0] lane_out;

  sabs_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  // One lane bank per width; the size field picks one bank's output.
  for (genvar g = 0; g < N_SIZES; g++) begin : g_bank
    sabs_lane_bank #(
      .VEC_W  (VEC_W),
      .LANE_W (8 << g)
    ) u_bank (
      .src_i (src_i),
      .neg_i (dec.negate),
      .res_o (bank_res[g])
    );
  end

  always_comb begin
    lane_sel = bank_res[dec.lsz];
    lane_out = dec.full ? lane_sel : (lane_sel & LOW_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      rd_o    <= '0;
      valid_o <= 1'b0;
      undef_o <= 1'b0;
    end else begin
      valid_o <= op_valid_i & dec.match;
      undef_o <= op_valid_i & ~dec.match;
      res_o   <= (op_valid_i && dec.match) ? lane_out : '0;
      if (op_valid_i) begin
        rd_o <= dec.rd;
      end
    end
  end

endmodule

// File: rtl/sabs_chk.sv
module sabs_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid_i,
  input logic [31:0]      instr_i,
  input logic [VEC_W-1:0] src_i,
  input logic [VEC_W-1:0] res_o,
  input logic [4:0]       rd_o,
  input logic             valid_o,
  input logic             undef_o
);

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (!valid_o && !undef_o && rd_o == 5'd0));

  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> !undef_o);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !op_valid_i |=> (!valid_o && !undef_o && res_o == '0));

  p_nomatch_undef_r9: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && instr_i[28:24] != 5'b01110 && instr_i[28:24] != 5'b11110)
      |=> (undef_o && res_o == '0));

  p_short_d_undef_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && instr_i[31:30] == 2'b00 && instr_i[28:22] == 7'b0111011 &&
     instr_i[21:10] == 12'b1000_0010_1110) |=> (undef_o && !valid_o));

  p_short_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && instr_i[31:30] == 2'b00) |=> (res_o[VEC_W-1:VEC_W/2] == '0));

  p_rd_capture_r12: assert property (@(posedge clk) disable iff (rst)
    op_valid_i |=> (rd_o == $past(instr_i[4:0])));

  p_byte_min_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && instr_i[31:22] == 10'b0100111000 &&
     instr_i[21:10] == 12'b1000_0010_1110 && src_i[7:0] == 8'h80)
      |=> (valid_o && res_o[7:0] == 8'h80));

endmodule

bind simd_absneg_unit sabs_chk #(.VEC_W(VEC_W)) u_sabs_chk (
  .clk        (clk),
  .rst        (rst),
  .op_valid_i (op_valid_i),
  .instr_i    (instr_i),
  .src_i      (src_i),
  .res_o      (res_o),
  .rd_o       (rd_o),
  .valid_o    (valid_o),
  .undef_o    (undef_o)
);

// File: tb/test_simd_absneg_unit.sv
`timescale 1ns/1ps
module test_simd_absneg_unit;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_valid = 1'b0;
  logic [31:0]  instr = '0;
  logic [127:0] src = '0;
  logic [127:0] res;
  logic [4:0]   rd;
  logic         valid;
  logic         undef;

  int   n_checks = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  logic [4:0] exp_rd = '0;

  always #2.5 clk = ~clk;

  simd_absneg_unit i_simd_absneg_unit (
    .clk        (clk),
    .rst        (rst),
    .op_valid_i (op_valid),
    .instr_i    (instr),
    .src_i      (src),
    .res_o      (res),
    .rd_o       (rd),
    .valid_o    (valid),
    .undef_o    (undef)
  );

  function automatic bit is_vec(input logic [31:0] w);
    return !w[31] && w[28:24] == 5'b01110 && w[21:10] == 12'b1000_0010_1110;
  endfunction

  function automatic bit is_sca(input logic [31:0] w);
    return w[31:30] == 2'b01 && w[28:24] == 5'b11110 && w[23:22] == 2'b11 &&
           w[21:10] == 12'b1000_0010_1110;
  endfunction

  function automatic bit legal(input logic [31:0] w);
    if (is_sca(w)) return 1'b1;
    if (is_vec(w)) return !(w[23:22] == 2'b11 && !w[30]);
    return 1'b0;
  endfunction

  function automatic logic [127:0] lanes(input logic [127:0] s, input int w,
                                         input int vlen, input bit neg);
    logic [127:0] r = '0;
    for (int i = 0; i < vlen / w; i++) begin
      logic [63:0] mask;
      logic [63:0] x;
      mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      x = 64'(s >> (i * w)) & mask;
      if (neg || x[w-1]) x = (~x + 64'd1) & mask;
      r = r | (128'(x) << (i * w));
    end
    return r;
  endfunction

  function automatic logic [127:0] model(input logic [31:0] w, input logic [127:0] s);
    if (!legal(w)) return '0;
    if (is_sca(w)) return lanes(s, 64, 64, w[29]);
    return lanes(s, 8 << w[23:22], w[30] ? 128 : 64, w[29]);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit v, input logic [31:0] w, input logic [127:0] s,
                       input string req);
    logic [127:0] e_res;
    bit e_val, e_und;
    @(negedge clk);
    op_valid = v; instr = w; src = s;
    e_val = v && legal(w);
    e_und = v && !legal(w);
    e_res = (v && legal(w)) ? model(w, s) : '0;
    if (v) exp_rd = w[4:0];
    @(posedge clk); #1;
    check(valid == e_val, req, "valid", 128'(valid), 128'(e_val));
    check(undef == e_und, req, "undef", 128'(undef), 128'(e_und));
    check(res == e_res, req, "result", res, e_res);
    check(rd == exp_rd, req, "rd", 128'(rd), 128'(exp_rd));
  endtask

  function automatic logic [127:0] spicy_src();
    logic [127:0] r;
    for (int b = 0; b < 16; b++) begin
      int k = int'($urandom % 8);
      logic [7:0] by = 8'($urandom);
      if (k == 0) by = 8'h80;
      else if (k == 1) by = 8'h00;
      else if (k == 2) by = 8'hFF;
      r[b*8 +: 8] = by;
    end
    return r;
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_checks++; n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check(!valid && !undef && res == '0 && rd == '0, "R11", "reset state",
          {res[123:0], valid, undef, 2'b00}, '0);
    @(negedge clk); rst = 1'b0;

    // R1 R3 R5: base word, byte lanes with 0x80, upper half must clear
    drive(1, 32'h0E20B800, 128'hDEADBEEF_CAFEF00D_80_7F_FF_01_80_00_FE_81, "R1 R3 R5");
    // R2 R4 R12: full vector, byte lanes, destination 7
    drive(1, 32'h4E20B807, 128'h8081_7F01_FFFE_0203_90A0_B0C0_D0E0_F000, "R2 R4 R12");
    // R2 R5: halfword lanes
    drive(1, 32'h4E60B81F, 128'h8000_7FFF_FFFF_0001_8001_1234_F00F_0000, "R2 R5");
    // R2: word lanes
    drive(1, 32'h4EA0B803, 128'h80000000_FFFFFFFF_7FFFFFFF_80000001, "R2 R4");
    // R2: doubleword lanes
    drive(1, 32'h4EE0B811, 128'h80000000_00000000_FFFFFFFF_FFFFFFFE, "R2 R5");
    // R6 R5: negate with bytes, min stays min
    drive(1, 32'h6E20B802, 128'h80_01_7F_FF_00_10_F0_80_80_01_7F_FF_00_10_F0_80, "R6 R5");
    // R6: negate halfwords, half vector
    drive(1, 32'h2E60B804, 128'h1111_2222_3333_4444_0005_8000_FFFF_7FFF, "R6 R3");
    // R8: Q=0 with 64-bit lanes
    drive(1, 32'h0EE0B80A, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, "R8");
    // R7: scalar absolute and negate
    drive(1, 32'h5EE0B805, 128'h1234_5678_9ABC_DEF0_8000_0000_0000_0001, "R7");
    drive(1, 32'h5EE0B806, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, "R7 R6");
    drive(1, 32'h7EE0B808, 128'h1234_5678_9ABC_DEF0_0000_0000_0000_0002, "R7 R6");
    // R9: garbage words
    drive(1, 32'hFFFFFFFF, 128'h5, "R9");
    drive(1, 32'h0E20B000, 128'h5, "R9");
    drive(1, 32'h5EA0B800, 128'h5, "R9");
    // R10: idle cycle with a legal word on the bus
    drive(0, 32'h4E20B809, 128'h8080_8080_8080_8080_8080_8080_8080_8080, "R10");

    // R11: reset during traffic
    @(negedge clk);
    rst = 1'b1; op_valid = 1'b1; instr = 32'h4E20B81E; src = '1;
    @(posedge clk); #1;
    exp_rd = '0;
    check(!valid && !undef && res == '0 && rd == '0, "R11", "mid-run reset",
          {res[123:0], valid, undef, 2'b00}, '0);
    @(negedge clk); rst = 1'b0;

    for (int n = 0; n < 600; n++) begin
      logic [31:0] w;
      int kind = int'($urandom % 8);
      w = $urandom;
      if (kind < 4) begin
        w[31] = 1'b0; w[28:24] = 5'b01110; w[21:10] = 12'b1000_0010_1110;
      end else if (kind == 4) begin
        w[31:30] = 2'b01; w[28:24] = 5'b11110; w[23:22] = 2'b11;
        w[21:10] = 12'b1000_0010_1110;
      end
      drive(kind != 7, w, spicy_src(), "R2 R4 R6 R7 R9");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule